// File: doc/BRIEF.md
# Pattern-Driven Pixel and Line Decimator

This block thins a raster video stream on the fly. Each incoming beat carries one pixel plus frame-start, line-start and line-end flags and an even/odd field indicator. Two 8-bit horizontal keep patterns, one per field parity, choose which pixels of every group of eight survive along a line. A third 8-bit pattern chooses which lines of every group of eight survive down a frame. All three patterns share a single 32-bit configuration word.

The surviving beats leave in their original order with `out_valid` high. The output markers are placed again so that they describe the thinned stream. A line that is dropped entirely leaves no trace at the output. Culling can be switched off, and the stream then passes through unchanged. The configuration, the field and the enable are captured at frame start, so a frame is always decimated with one consistent set of patterns.

Top module: `pix_culler`

## Requirements
- R1: The configuration word decodes as follows: the even-field pixel pattern is bits [31:24], the odd-field pixel pattern is bits [23:16], and the line pattern is bits [7:0]. For example, 0x239A0066 gives 0x23, 0x9A and 0x66.
- R2: A pattern bit of 1 keeps and 0 drops. Bit k of a pixel pattern applies to the pixel whose index within its line, modulo 8, equals k. The pixel index restarts at 0 on every line-start beat.
- R3: `in_field` = 0 selects the even-field pixel pattern and `in_field` = 1 selects the odd-field pixel pattern.
- R4: Bit k of the line pattern keeps or drops the line whose index within the frame, modulo 8, equals k. The line index restarts at 0 on the frame-start beat. A dropped line produces no output beat and no marker.
- R5: With `cull_en` = 0 at frame start, every beat of that frame reaches the output in order, with its data and markers unchanged.
- R6: The configuration word, field and enable sampled on the frame-start beat govern the whole frame. Changes to them later in the frame have no effect until the next frame start.
- R7: `out_eol` is asserted on the last kept pixel of each kept line, and on no other beat. This holds even when the input line-end pixel itself is dropped.
- R8: `out_sol` marks the first kept pixel of each kept line. `out_sof` marks the first kept pixel of the frame, and that beat also carries `out_sol`.
- R9: Output markers appear only with `out_valid`. Kept pixels keep their input order and data.
- R10: While `rst_n` is low and after its release, `out_valid` stays low until kept input arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cull_en | input | 1 | Culling enable, sampled at frame start |
| cfg_word | input | 32 | Packed pixel and line patterns, sampled at frame start |
| in_valid | input | 1 | Input beat present |
| in_sof | input | 1 | First beat of a frame (also a line start) |
| in_sol | input | 1 | First beat of a line |
| in_eol | input | 1 | Last beat of a line |
| in_field | input | 1 | Field parity, 0 even, 1 odd, sampled at frame start |
| in_data | input | DATA_W | Pixel value |
| out_valid | output | 1 | Kept beat present |
| out_sof | output | 1 | First kept beat of the frame |
| out_sol | output | 1 | First kept beat of a line |
| out_eol | output | 1 | Last kept beat of a line |
| out_data | output | DATA_W | Kept pixel value |

## Verification
A pixel phase counter that drifts shows up as a kept pattern that slides across the line. The first wrong pixel appears within eight beats of a line start. A line counter that is off by one swaps whole lines of the output in the next frame. A mishandled hold stage loses or duplicates `out_eol` at the next line boundary, or moves `out_eol` onto the wrong pixel. A latch that follows live configuration changes the kept pattern in the middle of a frame, at the first beat after the change. The bench compares every output beat, including its markers, against an independently built list of expected beats, and confirms that nothing is left over at the end of each frame.

// File: rtl/culler_pkg.sv
package culler_pkg;

  localparam int PAT_W = 8;
  localparam int PH_W  = $clog2(PAT_W);

  typedef logic [PAT_W-1:0] pat_t;
  typedef logic [PH_W-1:0]  phase_t;

  // pattern fields of the 32-bit configuration word
  function automatic pat_t cfg_even_pat(input logic [31:0] cfg);
    return cfg[31:24];
  endfunction

  function automatic pat_t cfg_odd_pat(input logic [31:0] cfg);
    return cfg[23:16];
  endfunction

  function automatic pat_t cfg_line_pat(input logic [31:0] cfg);
    return cfg[7:0];
  endfunction

  // 1 keeps the element whose index modulo PAT_W is the phase
  function automatic logic pat_keeps(input pat_t pat, input phase_t ph);
    return pat[ph];
  endfunction

  // index of the next element in the repeating group
  function automatic phase_t phase_next(input phase_t ph);
    return ph + phase_t'(1);
  endfunction

endpackage

// File: rtl/cull_cfg_latch.sv
module cull_cfg_latch
  import culler_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_beat,
  input  logic [31:0] cfg_word,
  input  logic        cull_en,
  input  logic        field,
  output pat_t        pix_pat,
  output pat_t        line_pat,
  output logic        en_eff
);

  pat_t even_q, odd_q, line_q;
  logic field_q, en_q;

  pat_t even_live, odd_live, line_live;
  assign even_live = cfg_even_pat(cfg_word);
  assign odd_live  = cfg_odd_pat(cfg_word);
  assign line_live = cfg_line_pat(cfg_word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      even_q  <= '1;
      odd_q   <= '1;
      line_q  <= '1;
      field_q <= 1'b0;
      en_q    <= 1'b0;
    end else if (frame_beat) begin
      even_q  <= even_live;
      odd_q   <= odd_live;
      line_q  <= line_live;
      field_q <= field;
      en_q    <= cull_en;
    end
  end

  // the frame-start beat itself uses the live values
  logic sel_field;
  assign sel_field = frame_beat ? field : field_q;
  assign en_eff    = frame_beat ? cull_en : en_q;
  assign line_pat  = frame_beat ? line_live : line_q;
  assign pix_pat   = frame_beat ? (sel_field ? odd_live : even_live)
                                : (sel_field ? odd_q : even_q);

  assert_cfg_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_beat |=> ($stable(even_q) && $stable(odd_q) && $stable(line_q)
                     && $stable(field_q) && $stable(en_q)));

endmodule

// File: rtl/cull_phase.sv
module cull_phase
  import culler_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic sof,
  input  logic sol,
  input  pat_t pix_pat,
  input  pat_t line_pat,
  input  logic en_eff,
  output logic keep,
  output logic line_kept
);

  phase_t pix_ph_q, line_ph_q;
  phase_t pix_idx, line_idx;

  assign pix_idx  = sol ? '0 : pix_ph_q;
  assign line_idx = sof ? '0 : (sol ? phase_next(line_ph_q) : line_ph_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_ph_q  <= '0;
      line_ph_q <= '0;
    end else if (beat) begin
      pix_ph_q  <= phase_next(pix_idx);
      line_ph_q <= line_idx;
    end
  end

  logic pix_hit;
  assign line_kept = !en_eff || pat_keeps(line_pat, line_idx);
  assign pix_hit   = !en_eff || pat_keeps(pix_pat, pix_idx);
  assign keep      = beat && line_kept && pix_hit;

  assert_pix_phase_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && sol) |=> (pix_ph_q == phase_t'(1)));

  assert_line_phase_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && sof) |=> (line_ph_q == '0));

  assert_line_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !sol) |=> $stable(line_ph_q));

endmodule

// File: rtl/cull_out_stage.sv
module cull_out_stage #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              keep,
  input  logic              sof,
  input  logic              sol,
  input  logic              eol,
  input  logic [DATA_W-1:0] data,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_sol,
  output logic              out_eol,
  output logic [DATA_W-1:0] out_data
);

  // marker arming until the first kept pixel
  logic sof_arm_q, sol_arm_q;
  logic tag_sof, tag_sol;

  assign tag_sof = keep && (sof || sof_arm_q);
  assign tag_sol = keep && (sol || sol_arm_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sof_arm_q <= 1'b0;
      sol_arm_q <= 1'b0;
    end else if (beat) begin
      sof_arm_q <= sof ? !keep : (sof_arm_q && !keep);
      sol_arm_q <= sol ? !keep : (sol_arm_q && !keep);
    end
  end

  // one-pixel hold so line end can land on the last kept pixel
  logic              hold_v_q, hold_sof_q, hold_sol_q, hold_last_q;
  logic [DATA_W-1:0] hold_data_q;
  logic              release_now, release_eol, line_closes;

  assign line_closes = beat && eol && !keep;
  assign release_now = hold_v_q && (hold_last_q || keep || line_closes);
  assign release_eol = hold_last_q || line_closes;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v_q    <= 1'b0;
      hold_sof_q  <= 1'b0;
      hold_sol_q  <= 1'b0;
      hold_last_q <= 1'b0;
      hold_data_q <= '0;
    end else if (keep) begin
      hold_v_q    <= 1'b1;
      hold_sof_q  <= tag_sof;
      hold_sol_q  <= tag_sol;
      hold_last_q <= eol;
      hold_data_q <= data;
    end else if (release_now) begin
      hold_v_q    <= 1'b0;
      hold_last_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_sol   <= 1'b0;
      out_eol   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= release_now;
      out_sof   <= release_now && hold_sof_q;
      out_sol   <= release_now && hold_sol_q;
      out_eol   <= release_now && release_eol;
      if (release_now) out_data <= hold_data_q;
    end
  end

  assert_markers_need_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(out_sof || out_sol || out_eol));

  assert_sof_carries_sol_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> out_sol);

  assert_idle_no_emit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat && !hold_last_q) |=> !out_valid);

  assert_close_emits_eol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v_q && line_closes) |=> (out_valid && out_eol));

endmodule

// File: rtl/pix_culler.sv
module pix_culler
  import culler_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cull_en,
  input  logic [31:0]       cfg_word,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_sol,
  input  logic              in_eol,
  input  logic              in_field,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_sol,
  output logic              out_eol,
  output logic [DATA_W-1:0] out_data
);

  logic frame_beat, sol_any;
  pat_t pix_pat, line_pat;
  logic en_eff, keep, line_kept;

  assign frame_beat = in_valid && in_sof;
  assign sol_any    = in_sol || in_sof;

  cull_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .frame_beat(frame_beat), .cfg_word(cfg_word),
    .cull_en(cull_en), .field(in_field), .pix_pat(pix_pat),
    .line_pat(line_pat), .en_eff(en_eff)
  );

  cull_phase u_phase (
    .clk(clk), .rst_n(rst_n), .beat(in_valid), .sof(in_sof), .sol(sol_any),
    .pix_pat(pix_pat), .line_pat(line_pat), .en_eff(en_eff),
    .keep(keep), .line_kept(line_kept)
  );

  cull_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .beat(in_valid), .keep(keep), .sof(in_sof),
    .sol(sol_any), .eol(in_eol), .data(in_data), .out_valid(out_valid),
    .out_sof(out_sof), .out_sol(out_sol), .out_eol(out_eol), .out_data(out_data)
  );

  assert_dropped_line_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !line_kept) |-> !keep);

  assert_bypass_keeps_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !en_eff) |-> keep);

endmodule

// File: tb/pix_culler_bench.sv
module pix_culler_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cull_en = 1'b0;
  logic [31:0] cfg_word = '0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0, in_eol = 1'b0, in_field = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, out_sof, out_sol, out_eol;
  logic [DW-1:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_culler #(.DATA_W(DW)) u_pix_culler (
    .clk(clk), .rst_n(rst_n), .cull_en(cull_en), .cfg_word(cfg_word),
    .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol), .in_eol(in_eol),
    .in_field(in_field), .in_data(in_data), .out_valid(out_valid),
    .out_sof(out_sof), .out_sol(out_sol), .out_eol(out_eol), .out_data(out_data)
  );

  typedef struct packed {
    logic [31:0] cfg;
    logic [31:0] cfg_alt;  // applied after the frame-start beat (R6)
    logic        en;
    logic        field;
    logic [7:0]  width;
    logic [7:0]  lines;
    logic [3:0]  gap;      // idle cycle after every gap beats, 0 = none
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h239A0066, 32'h239A0066, 1'b1, 1'b0, 8'd20, 8'd10, 4'd0}, // R1 R3 even
    '{32'h239A0066, 32'h239A0066, 1'b1, 1'b1, 8'd19, 8'd9,  4'd3}, // R1 R3 odd, gaps
    '{32'hFFFF00FF, 32'h00000000, 1'b0, 1'b0, 8'd10, 8'd3,  4'd0}, // R5 bypass
    '{32'h80010081, 32'h80010081, 1'b1, 1'b0, 8'd17, 8'd9,  4'd0}, // R7 dropped line end
    '{32'h239A0066, 32'h00000000, 1'b1, 1'b0, 8'd12, 8'd5,  4'd2}, // R6 mid-frame change
    '{32'h00FF00FF, 32'h00FF00FF, 1'b1, 1'b0, 8'd8,  8'd4,  4'd0}, // R3 all pixels dropped
    '{32'h01010001, 32'h01010001, 1'b1, 1'b1, 8'd1,  8'd9,  4'd0}  // R4 R8 one-pixel lines
  };

  int n_checks = 0;
  int n_errors = 0;
  logic [DW+2:0] exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: every output beat must be the next expected one
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4/R7/R9", "unexpected output beat", {17'd0, out_data, out_sof, out_sol, out_eol}, 32'd0);
      end else begin
        logic [DW+2:0] e;
        e = exp_q.pop_front();
        check({out_data, out_sof, out_sol, out_eol} == e, "R2/R4/R7/R8/R9", "output beat",
              {17'd0, out_data, out_sof, out_sol, out_eol}, {17'd0, e});
      end
    end
  end

  function automatic bit keeps(input logic [7:0] pat, input int idx);
    return ((pat >> (idx % 8)) & 8'd1) != 8'd0;
  endfunction

  function automatic logic [DW-1:0] pix_val(input int l, input int p);
    return DW'((l << 6) | p);
  endfunction

  task automatic build_expected(input vec_t v);
    logic [7:0] hp, vp;
    bit first_frame;
    hp = v.field ? v.cfg[23:16] : v.cfg[31:24];
    vp = v.cfg[7:0];
    first_frame = 1'b1;
    for (int l = 0; l < int'(v.lines); l++) begin
      int last_kept;
      bit first_line;
      if (v.en && !keeps(vp, l)) continue;
      last_kept = -1;
      for (int p = 0; p < int'(v.width); p++)
        if (!v.en || keeps(hp, p)) last_kept = p;
      first_line = 1'b1;
      for (int p = 0; p < int'(v.width); p++) begin
        if (v.en && !keeps(hp, p)) continue;
        exp_q.push_back({pix_val(l, p), first_frame, first_line, p == last_kept});
        first_frame = 1'b0;
        first_line = 1'b0;
      end
    end
  endtask

  task automatic drive_frame(input vec_t v);
    int sent;
    sent = 0;
    cfg_word = v.cfg;
    cull_en = v.en;
    in_field = v.field;
    for (int l = 0; l < int'(v.lines); l++) begin
      for (int p = 0; p < int'(v.width); p++) begin
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_sof = (l == 0 && p == 0);
        in_sol = (p == 0);
        in_eol = (p == int'(v.width) - 1);
        in_data = pix_val(l, p);
        if (!(l == 0 && p == 0)) begin
          cfg_word = v.cfg_alt;          // R6: later changes must be ignored
          in_field = (v.cfg_alt != v.cfg) ? !v.field : v.field;
          cull_en = (v.cfg_alt != v.cfg) ? !v.en : v.en;
        end
        sent++;
        if (v.gap != 0 && (sent % int'(v.gap)) == 0) begin
          @(posedge clk); #1;
          in_valid = 1'b0;
        end
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_sof = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", "run hung", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    // R10: output quiet while in reset
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R10", "valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R10", "valid after reset", {31'd0, out_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      build_expected(VECS[i]);
      drive_frame(VECS[i]);
      repeat (4) @(posedge clk);
      #1;
      // R4 R7: every expected beat seen, nothing left behind
      check(exp_q.size() == 0, "R4/R7", $sformatf("beats outstanding after vector %0d", i),
            exp_q.size(), 32'd0);
      exp_q.delete();
    end

    // R2: a short line after long ones restarts the pixel phase
    begin
      vec_t v;
      v = '{32'h05000000 | 32'h000000FF, 32'h050000FF, 1'b1, 1'b0, 8'd3, 8'd2, 4'd0};
      build_expected(v);
      check(exp_q.size() == 4, "R2", "expected beats for short lines", exp_q.size(), 32'd4);
      drive_frame(v);
      repeat (4) @(posedge clk);
      #1;
      check(exp_q.size() == 0, "R2", "short-line beats outstanding", exp_q.size(), 32'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule